// File: doc/BRIEF.md
# Daisy-chained design scan controller

This controller serves one long serial scan chain that runs through many small user designs. Each design owns an 8-bit slot of the chain. The chain carries that design's input byte in and its output byte out. The controller repeats one refresh without end. It shifts a fresh input image along the whole chain and pulses a latch strobe so that every design takes its slot as new inputs. It then pulses a capture strobe, which loads each design's outputs into its slot, and shifts the whole chain back. Only the design picked by the select input gets a non-zero input byte. Only that design's returned byte is gathered into the output register.

The scan clock runs at half the controller clock, so each chain bit costs two cycles. A design's clock or reset can be driven from software by toggling bits of the input byte across successive refreshes. With N designs a refresh lasts 32·N + 2 cycles: two shift phases of 16·N cycles each, plus one latch cycle and one capture cycle. The select value and input byte are snapshotted when a refresh starts. The output register changes only when a refresh ends.

Top module: `scan_chain_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, scan_clk_o, scan_data_o, latch_o and capture_o are low and data_o is 0.
- R2: During a shift phase scan_clk_o is low for one cycle and then high for one cycle, and this repeats once per chain bit. There are 8·N_DESIGNS rising edges per shift phase.
- R3: A refresh runs in this order: 16·N cycles of input shift, one cycle with latch_o high, one cycle with capture_o high, then 16·N cycles of output shift. Refreshes follow each other with no gap, so the period is 32·N+2 cycles.
- R4: The c-th bit shifted in (c from 0) is destined for chain position 8·N−1−c, where position 8·k+j is input bit j of design k and position 0 is the chain entry. scan_data_o does not change while scan_clk_o is high.
- R5: Every chain position outside the selected design's slot is shifted in as 0, so after the latch strobe all unselected designs hold input 0.
- R6: During output shift, scan_data_i is sampled in the cycle where scan_clk_o is low. The bit seen before the c-th rising edge comes from position 8·N−1−c. Bits from the selected slot form data_o, with position 8·sel+j going to data_o bit j.
- R7: data_o takes its new value on the edge that ends the output shift, and it holds its value in every other cycle.
- R8: sel_i and data_i are sampled only on the edge that starts a refresh. A change in the middle of a refresh takes effect from the next refresh.
- R9: If the select value is N_DESIGNS or more, every bit shifted in is 0, and the data_o value produced by that refresh is 0.
- R10: latch_o and capture_o are never high together, and neither is high while scan_clk_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | $clog2(N_DESIGNS) | Index of the active design |
| data_i | input | 8 | Input byte for the active design |
| data_o | output | 8 | Output byte of the active design from the last complete refresh |
| scan_clk_o | output | 1 | Scan clock, half rate |
| scan_data_o | output | 1 | Serial data into the chain entry |
| scan_data_i | input | 1 | Serial data from the chain end |
| latch_o | output | 1 | Strobe: designs take their slot as inputs |
| capture_o | output | 1 | Strobe: slots load the design outputs |

## Verification
The bench builds the controller with N_DESIGNS = 5. This gives a 40-bit chain and a 162-cycle refresh, so many refreshes fit in a short run. It also leaves select codes 5 to 7 free, which exercises the out-of-range case. A behavioural chain model in the bench applies a distinct per-design output function, so bit order, slot placement and end-to-end data_o can all be checked. Input changes that do not fall on refresh boundaries, and a reset in the middle of a run, test the snapshot timing and the recovery after reset.

// File: rtl/scan_ctrl_pkg.sv
package scan_ctrl_pkg;
  localparam int SLOT_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT_IN,
    ST_LATCH,
    ST_CAPTURE,
    ST_SHIFT_OUT
  } scan_state_e;
endpackage

// File: rtl/scan_seq.sv
module scan_seq
  import scan_ctrl_pkg::*;
#(
  parameter int N_DESIGNS = 498,
  parameter int CNT_W     = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output scan_state_e      st_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ph_o,
  output logic             start_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_DESIGNS * SLOT_BITS - 1);

  scan_state_e      st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ph_q;
  logic             last;

  assign last    = (cnt_q == LAST);
  assign done_o  = (st_q == ST_SHIFT_OUT) && ph_q && last;
  assign start_o = (st_q == ST_IDLE) || done_o;
  assign st_o    = st_q;
  assign cnt_o   = cnt_q;
  assign ph_o    = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          st_q  <= ST_SHIFT_IN;
          cnt_q <= '0;
          ph_q  <= 1'b0;
        end
        ST_SHIFT_IN, ST_SHIFT_OUT: begin
          ph_q <= ~ph_q;
          if (ph_q) begin
            if (last) begin
              cnt_q <= '0;
              st_q  <= (st_q == ST_SHIFT_IN) ? ST_LATCH : ST_SHIFT_IN;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_LATCH:   st_q <= ST_CAPTURE;
        ST_CAPTURE: begin
          st_q  <= ST_SHIFT_OUT;
          cnt_q <= '0;
          ph_q  <= 1'b0;
        end
        default:    st_q <= ST_IDLE;
      endcase
    end
  end

  assert_ph_toggle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SHIFT_IN && !ph_q) |=> ph_q);
endmodule

// File: rtl/scan_capture.sv
module scan_capture
  import scan_ctrl_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sample_i,
  input  logic [2:0]           bit_idx_i,
  input  logic                 scan_data_i,
  input  logic                 start_i,
  input  logic                 done_i,
  output logic [SLOT_BITS-1:0] data_o
);
  logic [SLOT_BITS-1:0] shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      data_o   <= '0;
    end else begin
      if (start_i)       shadow_q <= '0;
      else if (sample_i) shadow_q[bit_idx_i] <= scan_data_i;
      if (done_i)        data_o <= shadow_q;
    end
  end

  assert_dout_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(data_o));
endmodule

// File: rtl/scan_chain_ctrl.sv
module scan_chain_ctrl
  import scan_ctrl_pkg::*;
#(
  parameter int N_DESIGNS = 498,
  localparam int SEL_W    = $clog2(N_DESIGNS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic [SLOT_BITS-1:0] data_i,
  output logic [SLOT_BITS-1:0] data_o,
  output logic                 scan_clk_o,
  output logic                 scan_data_o,
  input  logic                 scan_data_i,
  output logic                 latch_o,
  output logic                 capture_o
);
  localparam int CNT_W = SEL_W + 3;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_DESIGNS * SLOT_BITS - 1);

  scan_state_e          st;
  logic [CNT_W-1:0]     cnt;
  logic                 ph, start, done;
  logic [CNT_W-1:0]     pos;
  logic                 match;
  logic [SEL_W-1:0]     sel_q;
  logic [SLOT_BITS-1:0] din_q;

  scan_seq #(.N_DESIGNS(N_DESIGNS), .CNT_W(CNT_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .st_o(st), .cnt_o(cnt), .ph_o(ph),
    .start_o(start), .done_o(done)
  );

  // chain position addressed by the current bit
  assign pos   = LAST - cnt;
  assign match = (pos[CNT_W-1:3] == sel_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      din_q <= '0;
    end else if (start) begin
      sel_q <= sel_i;
      din_q <= data_i;
    end
  end

  assign scan_clk_o  = ((st == ST_SHIFT_IN) || (st == ST_SHIFT_OUT)) && ph;
  assign scan_data_o = (st == ST_SHIFT_IN) && match && din_q[pos[2:0]];
  assign latch_o     = (st == ST_LATCH);
  assign capture_o   = (st == ST_CAPTURE);

  scan_capture u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sample_i((st == ST_SHIFT_OUT) && !ph && match),
    .bit_idx_i(pos[2:0]), .scan_data_i(scan_data_i),
    .start_i(start), .done_i(done), .data_o(data_o)
  );

  assert_clk_half_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_clk_o |=> !scan_clk_o);
  assert_latch_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_o |=> capture_o);
  assert_data_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_clk_o |-> $stable(scan_data_o));
endmodule

// File: tb/scan_chain_ctrl_bench.sv
module scan_chain_ctrl_bench;
  localparam int N  = 5;
  localparam int SW = $clog2(N);
  localparam int CB = N * 8;
  localparam int P  = 32 * N + 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [SW-1:0] sel_i = '0;
  logic [7:0]    data_i = '0;
  logic [7:0]    data_o;
  logic          scan_clk_o, scan_data_o, scan_data_i, latch_o, capture_o;

  scan_chain_ctrl #(.N_DESIGNS(N)) u_scan_chain_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .data_i(data_i),
    .data_o(data_o), .scan_clk_o(scan_clk_o), .scan_data_o(scan_data_o),
    .scan_data_i(scan_data_i), .latch_o(latch_o), .capture_o(capture_o)
  );

  always #2 clk_i = ~clk_i;

  int n_tests = 0, n_fail = 0, cycles = 0;
  int k = 0;
  int q_sel[$];
  int q_din[$];
  logic [CB-1:0] chain = '0;
  logic [7:0]    dmod[N];
  logic          prev_sc = 1'b0;

  assign scan_data_i = chain[CB-1];

  function automatic logic [7:0] fdes(int d, logic [7:0] x);
    logic [7:0] key = 8'((d * 29 + 3) & 255);
    return {x[3:0], x[7:4]} ^ key;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h (k=%0d)", tag, act, exp, k);
    end
  endtask

  // edges since reset release and the input snapshot of each refresh
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k = 0;
      q_sel.delete();
      q_din.delete();
    end else begin
      k++;
      if ((k - 1) % P == 0) begin
        q_sel.push_back(int'(sel_i));
        q_din.push_back(int'(data_i));
      end
    end
  end

  always @(negedge clk_i) begin
    int r, c, p, e_sc, e_sd, e_l, e_c, j, s, dn, e_do;
    cycles++;
    if (k == 0) begin
      chk("R1 scan_clk", int'(scan_clk_o), 0);
      chk("R1 scan_data", int'(scan_data_o), 0);
      chk("R1 strobes", int'({latch_o, capture_o}), 0);
      chk("R1 data_o", int'(data_o), 0);
    end else begin
      r = (k - 1) % P;
      s = q_sel[$];
      dn = q_din[$];
      e_sc = 0; e_sd = 0; e_l = 0; e_c = 0;
      if (r < 16 * N) begin
        c = r / 2;
        e_sc = r % 2;
        p = CB - 1 - c;
        if (s < N && p / 8 == s) e_sd = (dn >> (p % 8)) & 1;
      end else if (r == 16 * N) e_l = 1;
      else if (r == 16 * N + 1) e_c = 1;
      else e_sc = (r - 16 * N - 2) % 2;
      chk("R2 scan_clk", int'(scan_clk_o), e_sc);
      chk((s < N) ? "R4 scan_data" : "R9 scan_data", int'(scan_data_o), e_sd);
      chk("R3 latch", int'(latch_o), e_l);
      chk("R3 capture", int'(capture_o), e_c);
      chk("R10 strobe overlap", int'((latch_o && capture_o) ||
          ((latch_o || capture_o) && scan_clk_o)), 0);
      j = (k - 1) / P;
      if (j == 0) e_do = 0;
      else if (q_sel[j-1] >= N) e_do = 0;
      else e_do = int'(fdes(q_sel[j-1], 8'(q_din[j-1])));
      chk((j > 0 && q_sel[j-1] >= N) ? "R9 data_o" : "R6 R7 R8 data_o",
          int'(data_o), e_do);
    end
    // chain and design models
    if (scan_clk_o && !prev_sc) chain = {chain[CB-2:0], scan_data_o};
    prev_sc = scan_clk_o;
    if (latch_o)
      for (int d = 0; d < N; d++) dmod[d] = chain[d*8 +: 8];
    if (capture_o) begin
      for (int d = 0; d < N; d++) begin
        chk("R5 latched input", int'(dmod[d]),
            (d == q_sel[$]) ? q_din[$] : 0);
        chain[d*8 +: 8] = fdes(d, dmod[d]);
      end
    end
  end

  initial begin
    int sels[8] = '{0, 4, 2, 6, 1, 3, 7, 2};
    int dins[8] = '{8'hA5, 8'h3C, 8'hFF, 8'h81, 8'h00, 8'h5A, 8'h42, 8'h96};
    int waits[8] = '{170, 230, 150, 200, 163, 310, 175, 240};
    repeat (3) @(negedge clk_i);
    #1 rst_ni = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      #1 sel_i = SW'(sels[i]); data_i = 8'(dins[i]);
      repeat (waits[i]) @(negedge clk_i);
    end
    // reset in the middle of a refresh (R1)
    @(negedge clk_i);
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    #1 rst_ni = 1'b1;
    for (int i = 6; i < 8; i++) begin
      @(negedge clk_i);
      #1 sel_i = SW'(sels[i]); data_i = 8'(dins[i]);
      repeat (waits[i] + 200) @(negedge clk_i);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule